// File: doc/BRIEF.md
# Transmit-Only Display Data Streamer

This block is the monitor-facing port of a serial configuration memory that starts out in a streaming mode. After reset it sends the stored bytes out on a shared serial data line with no command. Each rising edge of a slow sync clock input (`vsync_clk_in`) moves the stream on by one bit. The first nine sync edges form a warm-up window in which the line is left undriven. From the tenth edge onward, bytes are sent most significant bit first. Each byte is followed by a ninth slot in which the line is released. Consecutive memory addresses are read in turn, and the address wraps from the last location back to zero.

A high-to-low transition on the bidirectional-mode clock input (`bus_clk_in`) moves the port for good into bidirectional mode. From then on the streamer never drives the data line again, and only a reset, which stands for a power cycle, brings the streaming mode back. Both asynchronous inputs pass through two-flop synchronizers into the system clock domain. The memory is external and is read through an address output and a byte input. The first address after reset is set by a parameter, so the host knows which byte comes first.

Top module: `ddc_stream_port`

## Requirements
- R1: After a synchronous reset, `bidir_mode` is 0, `sda_oe` is 0 and `mem_addr` equals the START_ADDR parameter (0 by default).
- R2: During the first nine rising edges of `vsync_clk_in` after reset, `sda_oe` stays 0.
- R3: On the tenth rising edge after reset, `sda_oe` becomes 1 and `sda_out` carries bit 7 of the byte at START_ADDR.
- R4: Each later rising edge of `vsync_clk_in` presents the next data bit, bit 7 down to bit 0. A falling edge of `vsync_clk_in` leaves `sda_oe` and `sda_out` unchanged.
- R5: The rising edge after bit 0 of a byte is a null slot in which `sda_oe` is 0.
- R6: At the start of the null slot, `mem_addr` advances by one. From DEPTH-1 it goes to 0, so the next byte comes from the following address. `mem_addr` never changes in any other way outside reset.
- R7: A falling edge of `bus_clk_in` sets `bidir_mode` to 1 and `sda_oe` to 0, whatever point the stream has reached. `bidir_mode` then stays 1 until reset, even when `bus_clk_in` returns high.
- R8: While `bidir_mode` is 1, edges on `vsync_clk_in` have no effect: `sda_oe` stays 0 and `mem_addr` holds.
- R9: A reset taken in bidirectional mode returns the port to streaming mode with a fresh nine-edge warm-up, followed by bit 7 of the byte at START_ADDR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| vsync_clk_in | input | 1 | Asynchronous streaming bit clock |
| bus_clk_in | input | 1 | Asynchronous bidirectional-mode clock, idle high |
| sda_oe | output | 1 | 1 while the data line is driven |
| sda_out | output | 1 | Data value when driven, 1 otherwise |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Byte at `mem_addr` |
| bidir_mode | output | 1 | 1 once bidirectional mode is entered |

## Verification
The stream is tried with a small table of bytes chosen to tell apart the likely faults. 8'h80 and 8'h01 expose bit-order reversal. 8'hA5 and 8'h5A expose a shifted or off-by-one bit index. The rest of the memory holds address-dependent values, and a full pass over all DEPTH locations up to the repeat of byte 0 separates a correct wrap from an early or missing one. The mode switch is tried in the middle of a byte, both with the bus clock restored high and with further sync edges. This shows the latch is permanent and that streaming is truly frozen. A second reset then checks that the warm-up count starts again from zero.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [1:0] {
    MODE_WARMUP = 2'd0,
    MODE_STREAM = 2'd1,
    MODE_BIDIR  = 2'd2
  } mode_t;

  localparam int SYNC_EDGES = 9;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
  parameter bit RST_VAL   = 1'b0,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic hit
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  generate
    if (FALL_EDGE) begin : g_fall
      assign hit = prev_q & ~sync_q;
    end else begin : g_rise
      assign hit = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/ddc_bit_seq.sv
module ddc_bit_seq
  import ddc_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int DW         = 8,
  parameter int START_ADDR = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = $clog2(DW + 1),
  localparam int IW = (DW > 1) ? $clog2(DW) : 1,
  localparam int CW = $clog2(SYNC_EDGES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          go_bidir,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic          oe,
  output logic          dout,
  output mode_t         mode
);
  logic [CW-1:0] warm_cnt;
  logic [BW-1:0] bit_pos;
  logic [IW-1:0] bit_idx;
  logic [AW-1:0] addr_nxt;

  assign bit_idx  = IW'(DW - 1) - bit_pos[IW-1:0];
  assign addr_nxt = (addr == AW'(DEPTH - 1)) ? '0 : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_WARMUP;
      warm_cnt <= '0;
      bit_pos  <= '0;
      addr     <= AW'(START_ADDR);
      oe       <= 1'b0;
      dout     <= 1'b1;
    end else if (go_bidir || mode == MODE_BIDIR) begin
      mode <= MODE_BIDIR;
      oe   <= 1'b0;
      dout <= 1'b1;
    end else if (step) begin
      case (mode)
        MODE_WARMUP: begin
          if (warm_cnt == CW'(SYNC_EDGES - 1)) mode <= MODE_STREAM;
          else warm_cnt <= warm_cnt + 1'b1;
        end
        MODE_STREAM: begin
          if (bit_pos == BW'(DW)) begin
            oe      <= 1'b0;
            dout    <= 1'b1;
            bit_pos <= '0;
            addr    <= addr_nxt;
          end else begin
            oe      <= 1'b1;
            dout    <= rdata[bit_idx];
            bit_pos <= bit_pos + 1'b1;
          end
        end
        default: mode <= MODE_BIDIR;
      endcase
    end
  end
endmodule

// File: rtl/ddc_stream_port.sv
module ddc_stream_port
  import ddc_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int DW         = 8,
  parameter int START_ADDR = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync_clk_in,
  input  logic          bus_clk_in,
  output logic          sda_oe,
  output logic          sda_out,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          bidir_mode
);
  logic  vs_rise;
  logic  bus_fall;
  mode_t mode;

  ddc_edge_sync #(.RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_vsync (
    .clk(clk), .rst(rst), .async_in(vsync_clk_in), .hit(vs_rise)
  );

  ddc_edge_sync #(.RST_VAL(1'b1), .FALL_EDGE(1'b1)) u_busclk (
    .clk(clk), .rst(rst), .async_in(bus_clk_in), .hit(bus_fall)
  );

  ddc_bit_seq #(.DEPTH(DEPTH), .DW(DW), .START_ADDR(START_ADDR)) u_seq (
    .clk(clk), .rst(rst), .step(vs_rise), .go_bidir(bus_fall),
    .rdata(mem_rdata), .addr(mem_addr), .oe(sda_oe), .dout(sda_out),
    .mode(mode)
  );

  assign bidir_mode = (mode == MODE_BIDIR);
endmodule

// File: rtl/ddc_stream_port_chk.sv
module ddc_stream_port_chk #(
  parameter int DEPTH      = 128,
  parameter int START_ADDR = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic [AW-1:0] mem_addr,
  input logic          bidir_mode
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bidir_mode && !sda_oe && mem_addr == AW'(START_ADDR)));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |->
      (mem_addr == (($past(mem_addr) == AW'(DEPTH - 1)) ? '0 : $past(mem_addr) + 1'b1)));

  p_bidir_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    bidir_mode |=> bidir_mode);

  p_quiet_in_bidir_r8: assert property (@(posedge clk) disable iff (rst)
    bidir_mode |-> !sda_oe);

  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    bidir_mode |=> $stable(mem_addr));
endmodule

bind ddc_stream_port ddc_stream_port_chk #(.DEPTH(DEPTH), .START_ADDR(START_ADDR)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .mem_addr(mem_addr), .bidir_mode(bidir_mode)
);

// File: tb/test_ddc_stream_port.sv
module test_ddc_stream_port;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int NPAT  = 4;
  localparam logic [7:0] PAT [NPAT] = '{8'h80, 8'h01, 8'hA5, 8'h5A};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vsync_clk_in = 1'b0;
  logic          bus_clk_in = 1'b1;
  logic          sda_oe, sda_out, bidir_mode;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [7:0]    bmem [DEPTH];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = bmem[mem_addr];

  ddc_stream_port #(.DEPTH(DEPTH), .DW(DW), .START_ADDR(0)) i_ddc_stream_port (
    .clk(clk), .rst(rst), .vsync_clk_in(vsync_clk_in), .bus_clk_in(bus_clk_in),
    .sda_oe(sda_oe), .sda_out(sda_out), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .bidir_mode(bidir_mode)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sync clock period; returns outputs after the high and low halves
  task automatic vpulse(output logic oe_h, output logic d_h,
                        output logic oe_l, output logic d_l);
    @(negedge clk) vsync_clk_in = 1'b1;
    wait_n(6);
    oe_h = sda_oe; d_h = sda_out;
    vsync_clk_in = 1'b0;
    wait_n(6);
    oe_l = sda_oe; d_l = sda_out;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
  endtask

  task automatic warmup(input string req);
    logic oh, dh, ol, dl;
    int   seen = 0;
    for (int i = 0; i < 9; i++) begin
      vpulse(oh, dh, ol, dl);
      if (oh || ol) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic stream_byte(input logic [7:0] exp, input int nxt, input string req);
    logic       oh, dh, ol, dl;
    logic [7:0] got = '0;
    int         oe_bad = 0;
    int         fall_bad = 0;
    for (int k = 0; k < 8; k++) begin
      vpulse(oh, dh, ol, dl);
      got = {got[6:0], dh};
      if (!oh) oe_bad++;
      if (ol !== oh || dl !== dh) fall_bad++;
    end
    chk({req, " R4 byte"}, got, exp);
    chk("R4 drive/falling-edge", oe_bad + fall_bad, 0);
    vpulse(oh, dh, ol, dl);
    chk("R5 null slot oe", oh, 1'b0);
    chk("R6 next addr", mem_addr, nxt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic oh, dh, ol, dl;
    logic [AW-1:0] held;
    for (int i = 0; i < DEPTH; i++) bmem[i] = 8'(i * 29 + 3) ^ 8'h3C;
    for (int i = 0; i < NPAT; i++) bmem[i] = PAT[i];

    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    chk("R1 bidir", bidir_mode, 0);
    chk("R1 oe", sda_oe, 0);
    chk("R1 addr", mem_addr, 0);

    // R2 warm-up
    warmup("R2 warm-up undriven");

    // table walk; first byte also covers R3
    for (int b = 0; b < NPAT; b++)
      stream_byte(PAT[b], b + 1, (b == 0) ? "R3" : "table");

    // remaining array and wrap (R6)
    for (int b = NPAT; b < DEPTH; b++)
      stream_byte(bmem[b], (b + 1) % DEPTH, "array");
    stream_byte(PAT[0], 1, "R6 after wrap");

    // switch mid-byte (R7)
    vpulse(oh, dh, ol, dl);
    vpulse(oh, dh, ol, dl);
    @(negedge clk) bus_clk_in = 1'b0;
    wait_n(6);
    chk("R7 bidir set", bidir_mode, 1);
    chk("R7 oe released", sda_oe, 0);
    bus_clk_in = 1'b1;
    wait_n(6);
    chk("R7 sticky after bus clk high", bidir_mode, 1);

    // R8 sync edges ignored
    held = mem_addr;
    for (int i = 0; i < 10; i++) begin
      vpulse(oh, dh, ol, dl);
      if (oh || ol) n_bad += 0;
      chk("R8 oe stays low", {oh, ol}, 2'b00);
    end
    chk("R8 addr held", mem_addr, held);
    chk("R7 still bidir", bidir_mode, 1);

    // R9 reset restores streaming
    do_reset();
    chk("R9 bidir cleared", bidir_mode, 0);
    chk("R9 addr", mem_addr, 0);
    warmup("R9 warm-up again");
    vpulse(oh, dh, ol, dl);
    chk("R9 first bit drive", oh, 1);
    chk("R9 first bit value", dh, PAT[0][7]);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule